// File: doc/BRIEF.md
# UART Interrupt and DMA Request Generator

This block decides, for one UART channel, when the receive path, the transmit path and the receive-error logic ask for attention. The datapath reports shifter handoff events with the FIFO occupancy that results from each one, and one-cycle error pulses. Two configuration inputs, one per direction, choose whether that direction stays quiet, raises interrupt pulses, or raises DMA requests. A FIFO-enable input picks between trigger-level matching and a request on every handoff.

Receive errors are gathered into a sticky, clear-on-read status vector, so that software can tell which condition caused an error interrupt. The three transfer-status levels (receive data ready, transmit buffer empty, transmit shifter empty) are registered and presented next to the error vector.

Top module: `uart_irq_dma_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, every output is 0.
- R2: Direction mode codes are 0 = off, 1 = interrupt/polling, 2 = DMA, 3 = off (reserved). In an off mode, no interrupt pulse and no new DMA request come from that direction.
- R3: With fifo_en_i = 1 and rx_mode_i = 1, a cycle with rx_xfer_i = 1 and rx_fill_i equal to rx_trig_i makes rx_irq_o high for exactly the next cycle. A handoff with any other fill level gives no pulse.
- R4: With fifo_en_i = 0 and rx_mode_i = 1, every cycle with rx_xfer_i = 1 makes rx_irq_o high for exactly the next cycle, whatever the fill and trigger values.
- R5: With fifo_en_i = 1 and tx_mode_i = 1, a cycle with tx_xfer_i = 1 and tx_left_i equal to tx_trig_i makes tx_irq_o high for exactly the next cycle. Other counts give no pulse.
- R6: With fifo_en_i = 0 and tx_mode_i = 1, every cycle with tx_xfer_i = 1 makes tx_irq_o high for exactly the next cycle.
- R7: In mode 2, the event that would pulse a direction's interrupt sets that direction's DMA request from the next cycle on, and no interrupt pulse is produced. The request stays high until a cycle with the matching ack input high, and drops in the cycle after that one. If an event and an ack arrive in the same cycle, the request stays set.
- R8: err_status_o bit 0 = overrun, bit 1 = parity, bit 2 = framing, bit 3 = break. Each bit is set in the cycle after its error pulse, whatever err_irq_en_i is, and holds until a cycle with err_rd_i = 1 clears it. An error pulse in the same cycle as err_rd_i leaves its bit set.
- R9: err_irq_o is high for exactly one cycle, the cycle after any error pulse, but only when err_irq_en_i = 1 in the cycle of the pulse.
- R10: trx_status_o bit 0 = receive data ready, bit 1 = transmit buffer empty, bit 2 = transmit shifter empty. Each bit follows its input with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1 = trigger-level rules, 0 = request on every handoff |
| rx_mode_i | input | 2 | Receive mode code |
| tx_mode_i | input | 2 | Transmit mode code |
| rx_trig_i | input | CW | Receive trigger level |
| tx_trig_i | input | CW | Transmit trigger level |
| err_irq_en_i | input | 1 | Error interrupt enable |
| rx_xfer_i | input | 1 | Receive shifter handed a word to FIFO/holding register |
| rx_fill_i | input | CW | Receive FIFO word count after the handoff |
| tx_xfer_i | input | 1 | Transmit FIFO/holding register handed a word to the shifter |
| tx_left_i | input | CW | Transmit FIFO words left after the handoff |
| ovr_err_i | input | 1 | Overrun pulse |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_err_i | input | 1 | Break pulse |
| err_rd_i | input | 1 | Read strobe of the error status vector |
| rx_ready_i | input | 1 | Receive data ready level |
| tx_buf_empty_i | input | 1 | Transmit buffer empty level |
| tx_shift_empty_i | input | 1 | Transmit shifter empty level |
| rx_dma_ack_i | input | 1 | Receive DMA acknowledge |
| tx_dma_ack_i | input | 1 | Transmit DMA acknowledge |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| err_irq_o | output | 1 | Receive error interrupt pulse |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| err_status_o | output | 4 | Sticky error status |
| trx_status_o | output | 3 | Registered transfer status |

## Verification
Two pairs of actions can land in the same cycle: a status read with a fresh error pulse, and a DMA acknowledge with a new handoff event. The bench drives every pair of sixteen prior-error and sixteen colliding-error patterns with the read strobe high, and expects exactly the new pattern to remain. It also raises an ack together with a triggering event and expects the request to stay up, then drops it with an ack alone.

// File: rtl/uart_req_pkg.sv
package uart_req_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_IRQ  = 2'd1,
    MODE_DMA  = 2'd2,
    MODE_RSVD = 2'd3
  } req_mode_e;

  localparam int unsigned N_DIR  = 2;
  localparam int unsigned DIR_RX = 0;
  localparam int unsigned DIR_TX = 1;
  localparam int unsigned N_ERR  = 4;
  localparam int unsigned N_TRX  = 3;

  // bit 0 = overrun ... bit 3 = break
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } err_vec_t;
endpackage

// File: rtl/uart_req_dir.sv
module uart_req_dir
  import uart_req_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] trig_i,
  input  logic          xfer_i,
  input  logic [CW-1:0] level_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic          dma_o
);
  req_mode_e mode;
  logic      hit;
  logic      irq_q, dma_q;

  assign mode = req_mode_e'(mode_i);
  // FIFO rule: match on trigger level; otherwise every handoff counts
  assign hit  = xfer_i && (!fifo_en_i || (level_i == trig_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      irq_q <= hit && (mode == MODE_IRQ);
      if (hit && (mode == MODE_DMA)) dma_q <= 1'b1;
      else if (ack_i)                dma_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
  assign dma_o = dma_q;
endmodule

// File: rtl/uart_err_track.sv
module uart_err_track
  import uart_req_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t err_i,
  input  logic     en_i,
  input  logic     rd_i,
  output err_vec_t status_o,
  output logic     irq_o
);
  err_vec_t status_q;
  logic     irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      // new error beats the clearing read
      status_q <= (rd_i ? err_vec_t'('0) : status_q) | err_i;
      irq_q    <= en_i && (|err_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/uart_irq_dma_gen.sv
module uart_irq_dma_gen
  import uart_req_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic [1:0]    rx_mode_i,
  input  logic [1:0]    tx_mode_i,
  input  logic [CW-1:0] rx_trig_i,
  input  logic [CW-1:0] tx_trig_i,
  input  logic          err_irq_en_i,
  input  logic          rx_xfer_i,
  input  logic [CW-1:0] rx_fill_i,
  input  logic          tx_xfer_i,
  input  logic [CW-1:0] tx_left_i,
  input  logic          ovr_err_i,
  input  logic          par_err_i,
  input  logic          frm_err_i,
  input  logic          brk_err_i,
  input  logic          err_rd_i,
  input  logic          rx_ready_i,
  input  logic          tx_buf_empty_i,
  input  logic          tx_shift_empty_i,
  input  logic          rx_dma_ack_i,
  input  logic          tx_dma_ack_i,
  output logic          rx_irq_o,
  output logic          tx_irq_o,
  output logic          err_irq_o,
  output logic          rx_dma_req_o,
  output logic          tx_dma_req_o,
  output logic [3:0]    err_status_o,
  output logic [2:0]    trx_status_o
);
  logic [1:0]    mode_a  [N_DIR];
  logic [CW-1:0] trig_a  [N_DIR];
  logic [CW-1:0] level_a [N_DIR];
  logic [N_DIR-1:0] xfer_v, ack_v, irq_v, dma_v;

  assign mode_a[DIR_RX]  = rx_mode_i;
  assign mode_a[DIR_TX]  = tx_mode_i;
  assign trig_a[DIR_RX]  = rx_trig_i;
  assign trig_a[DIR_TX]  = tx_trig_i;
  assign level_a[DIR_RX] = rx_fill_i;
  assign level_a[DIR_TX] = tx_left_i;
  assign xfer_v = {tx_xfer_i, rx_xfer_i};
  assign ack_v  = {tx_dma_ack_i, rx_dma_ack_i};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    uart_req_dir #(.CW(CW)) dir_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fifo_en_i (fifo_en_i),
      .mode_i    (mode_a[d]),
      .trig_i    (trig_a[d]),
      .xfer_i    (xfer_v[d]),
      .level_i   (level_a[d]),
      .ack_i     (ack_v[d]),
      .irq_o     (irq_v[d]),
      .dma_o     (dma_v[d])
    );
  end

  assign rx_irq_o     = irq_v[DIR_RX];
  assign tx_irq_o     = irq_v[DIR_TX];
  assign rx_dma_req_o = dma_v[DIR_RX];
  assign tx_dma_req_o = dma_v[DIR_TX];

  err_vec_t err_in, err_st;
  assign err_in = '{brk: brk_err_i, frm: frm_err_i, par: par_err_i, ovr: ovr_err_i};

  uart_err_track err_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_in),
    .en_i     (err_irq_en_i),
    .rd_i     (err_rd_i),
    .status_o (err_st),
    .irq_o    (err_irq_o)
  );
  assign err_status_o = err_st;

  uart_stat_reg #(.W(N_TRX)) trx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tx_shift_empty_i, tx_buf_empty_i, rx_ready_i}),
    .q_o    (trx_status_o)
  );
endmodule

// File: rtl/uart_irq_dma_gen_chk.sv
module uart_irq_dma_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] rx_mode_i,
  input logic [1:0] tx_mode_i,
  input logic       rx_xfer_i,
  input logic       tx_xfer_i,
  input logic       err_irq_en_i,
  input logic       err_rd_i,
  input logic       rx_dma_ack_i,
  input logic       tx_dma_ack_i,
  input logic       rx_irq_o,
  input logic       tx_irq_o,
  input logic       rx_dma_req_o,
  input logic       tx_dma_req_o,
  input logic       err_irq_o,
  input logic [3:0] err_status_o
);
  assert_rx_irq_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> ($past(rx_xfer_i) && $past(rx_mode_i) == 2'd1));
  assert_tx_irq_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> ($past(tx_xfer_i) && $past(tx_mode_i) == 2'd1));
  assert_rx_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mode_i == 2'd0 || rx_mode_i == 2'd3) |=> !rx_irq_o);
  assert_tx_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_i == 2'd0 || tx_mode_i == 2'd3) |=> !tx_irq_o);
  assert_rx_dma_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dma_req_o && !rx_dma_ack_i) |=> rx_dma_req_o);
  assert_tx_dma_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dma_req_o && !tx_dma_ack_i) |=> tx_dma_req_o);
  assert_rx_dma_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dma_req_o) |-> ($past(rx_xfer_i) && $past(rx_mode_i) == 2'd2));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_rd_i |=> ((err_status_o & $past(err_status_o)) == $past(err_status_o)));
  assert_err_irq_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> $past(err_irq_en_i));
endmodule

bind uart_irq_dma_gen uart_irq_dma_gen_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_mode_i    (rx_mode_i),
  .tx_mode_i    (tx_mode_i),
  .rx_xfer_i    (rx_xfer_i),
  .tx_xfer_i    (tx_xfer_i),
  .err_irq_en_i (err_irq_en_i),
  .err_rd_i     (err_rd_i),
  .rx_dma_ack_i (rx_dma_ack_i),
  .tx_dma_ack_i (tx_dma_ack_i),
  .rx_irq_o     (rx_irq_o),
  .tx_irq_o     (tx_irq_o),
  .rx_dma_req_o (rx_dma_req_o),
  .tx_dma_req_o (tx_dma_req_o),
  .err_irq_o    (err_irq_o),
  .err_status_o (err_status_o)
);

// File: tb/uart_irq_dma_gen_tb_top.sv
module uart_irq_dma_gen_tb_top;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fifo_en, err_en, err_rd;
  logic [1:0] rx_mode, tx_mode;
  logic [CW-1:0] rx_trig, tx_trig, rx_fill, tx_left;
  logic rx_xfer, tx_xfer, rx_ack, tx_ack;
  logic [3:0] errs;
  logic [2:0] lvls;
  logic rx_irq, tx_irq, err_irq, rx_dma, tx_dma;
  logic [3:0] err_st;
  logic [2:0] trx_st;

  uart_irq_dma_gen #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en),
    .rx_mode_i(rx_mode), .tx_mode_i(tx_mode),
    .rx_trig_i(rx_trig), .tx_trig_i(tx_trig), .err_irq_en_i(err_en),
    .rx_xfer_i(rx_xfer), .rx_fill_i(rx_fill), .tx_xfer_i(tx_xfer), .tx_left_i(tx_left),
    .ovr_err_i(errs[0]), .par_err_i(errs[1]), .frm_err_i(errs[2]), .brk_err_i(errs[3]),
    .err_rd_i(err_rd), .rx_ready_i(lvls[0]), .tx_buf_empty_i(lvls[1]),
    .tx_shift_empty_i(lvls[2]), .rx_dma_ack_i(rx_ack), .tx_dma_ack_i(tx_ack),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .err_irq_o(err_irq),
    .rx_dma_req_o(rx_dma), .tx_dma_req_o(tx_dma),
    .err_status_o(err_st), .trx_status_o(trx_st)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  function automatic int irq_of(int d);
    return d == 0 ? int'(rx_irq) : int'(tx_irq);
  endfunction
  function automatic int dma_of(int d);
    return d == 0 ? int'(rx_dma) : int'(tx_dma);
  endfunction

  task automatic set_dir(int d, logic [1:0] m, logic [CW-1:0] t, logic [CW-1:0] l, logic x, logic a);
    if (d == 0) begin rx_mode = m; rx_trig = t; rx_fill = l; rx_xfer = x; rx_ack = a; end
    else        begin tx_mode = m; tx_trig = t; tx_left = l; tx_xfer = x; tx_ack = a; end
  endtask

  task automatic sweep_dir(int d);
    for (int fe = 0; fe < 2; fe++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t <= DEPTH; t++)
          for (int l = 0; l <= DEPTH; l++) begin
            bit hit;
            string tag;
            hit = (fe == 0) || (l == t);
            if (m == 0 || m == 3)  tag = "R2";
            else if (m == 2)       tag = "R7";
            else if (d == 0)       tag = fe ? "R3" : "R4";
            else                   tag = fe ? "R5" : "R6";
            @(negedge clk);
            fifo_en = fe[0];
            set_dir(d, m[1:0], t[CW-1:0], l[CW-1:0], 1'b1, 1'b0);
            @(negedge clk);
            set_dir(d, m[1:0], t[CW-1:0], l[CW-1:0], 1'b0, 1'b0);
            chk(tag, irq_of(d), int'(hit && m == 1));
            chk(tag, dma_of(d), int'(hit && m == 2));
            @(negedge clk);
            chk(tag, irq_of(d), 0);
            chk(tag, dma_of(d), int'(hit && m == 2));
            set_dir(d, m[1:0], t[CW-1:0], l[CW-1:0], 1'b0, 1'b1);
            @(negedge clk);
            set_dir(d, 2'd0, '0, '0, 1'b0, 1'b0);
            chk("R7", dma_of(d), 0);
          end
  endtask

  task automatic ack_collide(int d);
    @(negedge clk);
    fifo_en = 1'b0;
    set_dir(d, 2'd2, '0, '0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7", dma_of(d), 1);
    set_dir(d, 2'd2, '0, '0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7", dma_of(d), 1);
    chk("R7", irq_of(d), 0);
    set_dir(d, 2'd2, '0, '0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7", dma_of(d), 0);
    set_dir(d, 2'd0, '0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; err_en = 1'b0; err_rd = 1'b0;
    rx_mode = '0; tx_mode = '0; rx_trig = '0; tx_trig = '0;
    rx_fill = '0; tx_left = '0; rx_xfer = 1'b0; tx_xfer = 1'b0;
    rx_ack = 1'b0; tx_ack = 1'b0; errs = '0; lvls = '0;
    repeat (3) @(negedge clk);
    lvls = 3'b111; errs = 4'hf; rx_xfer = 1'b1; rx_mode = 2'd1;
    @(negedge clk);
    chk("R1", int'({rx_irq, tx_irq, err_irq, rx_dma, tx_dma}), 0);
    chk("R1", int'({err_st, trx_st}), 0);
    lvls = '0; errs = '0; rx_xfer = 1'b0; rx_mode = 2'd0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'({rx_irq, tx_irq, err_irq, rx_dma, tx_dma}), 0);
    chk("R1", int'({err_st, trx_st}), 0);

    sweep_dir(0);
    sweep_dir(1);
    ack_collide(0);
    ack_collide(1);

    // error status: capture, stickiness, read collision, accumulation
    for (int en = 0; en < 2; en++)
      for (int p = 0; p < 16; p++)
        for (int q = 0; q < 16; q++) begin
          @(negedge clk);
          err_en = en[0]; errs = p[3:0]; err_rd = 1'b0;
          @(negedge clk);
          errs = '0;
          chk("R8", int'(err_st), p);
          chk("R9", int'(err_irq), int'(en == 1 && p != 0));
          @(negedge clk);
          chk("R8", int'(err_st), p);
          chk("R9", int'(err_irq), 0);
          errs = q[3:0]; err_rd = 1'b1;
          @(negedge clk);
          chk("R8", int'(err_st), q);
          chk("R9", int'(err_irq), int'(en == 1 && q != 0));
          errs = p[3:0]; err_rd = 1'b0;
          @(negedge clk);
          chk("R8", int'(err_st), p | q);
          errs = '0; err_rd = 1'b1;
          @(negedge clk);
          err_rd = 1'b0;
          chk("R8", int'(err_st), 0);
        end

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      lvls = v[2:0];
      @(negedge clk);
      chk("R10", int'(trx_st), v);
    end

    summary();
  end
endmodule